// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block tracks which power state a small microcontroller core is in: normal run, low-power run, a shallow stop that keeps the regulator, a deep stop with part of the chip powered down, and active debug. It takes a stop strobe from the instruction decoder, interrupt and debug wake strobes, and writes to a six-bit control word. From these it works out the next mode. It also drives the regulator-standby request and the debug-clock keep-alive, and it reports a one-cycle error pulse when a debugger tries a memory access while the core is stopped.

A deep-stop request is quietly downgraded to shallow stop in three cases: the debugger is enabled, low-voltage detection is armed for stop, or the request comes from low-power run. The two run-mode control bits (partial power-down select and low-power-run request) cannot both be set. A control bit chooses whether an interrupt wake from shallow stop goes back to low-power run or forces normal run.

Top module: `lpm_sequencer`

## Requirements
- R1: While `rstN` is low, and after it is released, `mode` is 0 and `cfgBits` is 0. `regStandby`, `dbgClkOn`, `lprStat` and `memErr` are all 0.
- R2: `mode` uses 0 for run, 1 for low-power run, 2 for shallow stop, 3 for deep stop and 4 for debug, and it changes on the clock edge that samples the trigger. A `stopReq` in run with `cfgBits[3]` (power-down select) clear enters shallow stop.
- R3: A `stopReq` in run with `cfgBits[3]` set enters deep stop, unless `cfgBits[0]` (debug enable) is set, in which case it enters shallow stop.
- R4: When `cfgBits[1]` and `cfgBits[2]` (voltage detect enable, detect-in-stop enable) are both set, a deep-stop request enters shallow stop. When only one of them is set, the request still enters deep stop.
- R5: On a `cfgWr`, the bits `cfgData[0]`, `[1]`, `[2]` and `[5]` load directly. A 1 written to `[3]` (power-down select) or to `[4]` (low-power-run request) is dropped if the other bit is set at that moment. If both bits are clear and both are written 1, both stay clear.
- R6: While in run, a set `cfgBits[4]` moves `mode` to low-power run on the next edge. In low-power run, a clear `cfgBits[4]` returns to run. `lprStat` is 1 exactly in low-power run. A `stopReq` from low-power run always enters shallow stop, never deep stop.
- R7: An `irqWake` in shallow stop with `cfgBits[5]` (wake-to-normal) clear goes to low-power run if `cfgBits[4]` is set, and to run otherwise. With `cfgBits[5]` set it goes to run and clears `cfgBits[4]`. An `irqWake` in deep stop goes to run.
- R8: A `dbgWake` enters debug from any other mode only when `cfgBits[0]` is set; otherwise it leaves the mode unchanged. `dbgWake` has priority over `irqWake`, and `irqWake` over `stopReq`. In debug, `dbgResume` returns to run.
- R9: `regStandby` is 1 in either stop mode when debug enable is clear and the voltage-detect pair is not both set. `dbgClkOn` is 1 in either stop mode when debug enable is set. Both are 0 outside stop.
- R10: `memErr` pulses high for one cycle, on the edge after a `memReq` made in a stop mode. A `memReq` in any other mode leaves it low.
- R11: Pulling `rstN` low in any mode, stop included, returns `mode` to run and clears all control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReq | input | 1 | Stop instruction strobe |
| irqWake | input | 1 | Interrupt wake strobe |
| dbgWake | input | 1 | Debug wake command strobe |
| dbgResume | input | 1 | Debug resume command strobe |
| memReq | input | 1 | Debug memory-access request strobe |
| cfgWr | input | 1 | Control word write strobe |
| cfgData | input | 6 | Control word write data |
| mode | output | 3 | Current power mode |
| cfgBits | output | 6 | Current control word |
| regStandby | output | 1 | Regulator standby request |
| dbgClkOn | output | 1 | Debug clock keep-alive |
| lprStat | output | 1 | Low-power run status |
| memErr | output | 1 | Error pulse for a memory request while stopped |

## Verification
Assertions check four things on every cycle: the two run-mode bits are never set together, low-power run never steps straight into deep stop, a debug wake with debug enable clear never reaches debug, and every error pulse follows a memory request made while stopped. The wake-to-normal path is also checked every cycle for its landing mode. Only the bench scenarios show the rest: the demotion of deep stop by the debug and voltage-detect conditions, the exact outcome of each lockout write, the bit clear on wake-to-normal, the standby and keep-alive outputs, and reset out of a stop mode. The random phase compares every output against a reference model on every cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W = 3;
  localparam int CFG_W  = 6;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN     = 3'd0,
    MODE_LPRUN   = 3'd1,
    MODE_SHALLOW = 3'd2,
    MODE_DEEP    = 3'd3,
    MODE_DEBUG   = 3'd4
  } mode_e;

  // bit 0 is dbgEn, bit 5 is wakeNorm
  typedef struct packed {
    logic wakeNorm;
    logic lprReq;
    logic ppdSel;
    logic lvdStopEn;
    logic lvdEn;
    logic dbgEn;
  } cfg_t;

  typedef struct packed {
    logic clrLpr;
    logic inStop;
  } ctl_t;
endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             memReq,
  input  ctl_t             ctl,
  output cfg_t             cfgQ,
  output logic             regStandby,
  output logic             dbgClkOn,
  output logic             memErr
);
  cfg_t wrCfg;
  cfg_t nextCfg;
  logic ppdOk;
  logic lprOk;

  always_comb begin
    wrCfg   = cfg_t'(cfgData);
    // a 1 sticks only if the partner bit is clear now and not being raised alongside
    ppdOk   = wrCfg.ppdSel && !cfgQ.lprReq && !(wrCfg.lprReq && !cfgQ.ppdSel);
    lprOk   = wrCfg.lprReq && !cfgQ.ppdSel && !(wrCfg.ppdSel && !cfgQ.lprReq);
    nextCfg = wrCfg;
    nextCfg.ppdSel = ppdOk;
    nextCfg.lprReq = lprOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= '0;
      memErr <= 1'b0;
    end else begin
      if (cfgWr) cfgQ <= nextCfg;
      if (ctl.clrLpr) cfgQ.lprReq <= 1'b0;
      memErr <= memReq && ctl.inStop;
    end
  end

  always_comb begin
    regStandby = ctl.inStop && !cfgQ.dbgEn && !(cfgQ.lvdEn && cfgQ.lvdStopEn);
    dbgClkOn   = ctl.inStop && cfgQ.dbgEn;
  end

  p_lock_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgQ.ppdSel && cfgQ.lprReq));

  p_err_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    memErr |-> $past(memReq && ctl.inStop));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  stopReq,
  input  logic  irqWake,
  input  logic  dbgWake,
  input  logic  dbgResume,
  input  cfg_t  cfg,
  output mode_e state,
  output ctl_t  ctl
);
  mode_e nextState;
  logic  clrLpr;
  logic  dbgOk;
  logic  lvdHold;
  logic  deepOk;

  always_comb begin
    dbgOk     = dbgWake && cfg.dbgEn;
    lvdHold   = cfg.lvdEn && cfg.lvdStopEn;
    deepOk    = cfg.ppdSel && !cfg.dbgEn && !lvdHold;
    nextState = state;
    clrLpr    = 1'b0;
    case (state)
      MODE_RUN: begin
        if (dbgOk)            nextState = MODE_DEBUG;
        else if (stopReq)     nextState = deepOk ? MODE_DEEP : MODE_SHALLOW;
        else if (cfg.lprReq)  nextState = MODE_LPRUN;
      end
      MODE_LPRUN: begin
        if (dbgOk)            nextState = MODE_DEBUG;
        else if (stopReq)     nextState = MODE_SHALLOW;
        else if (!cfg.lprReq) nextState = MODE_RUN;
      end
      MODE_SHALLOW: begin
        if (dbgOk) nextState = MODE_DEBUG;
        else if (irqWake) begin
          if (cfg.wakeNorm) begin
            nextState = MODE_RUN;
            clrLpr    = 1'b1;
          end else begin
            nextState = cfg.lprReq ? MODE_LPRUN : MODE_RUN;
          end
        end
      end
      MODE_DEEP: begin
        if (dbgOk)        nextState = MODE_DEBUG;
        else if (irqWake) nextState = MODE_RUN;
      end
      MODE_DEBUG: begin
        if (dbgResume) nextState = MODE_RUN;
      end
      default: nextState = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MODE_RUN;
    else       state <= nextState;
  end

  always_comb begin
    ctl.clrLpr = clrLpr;
    ctl.inStop = (state == MODE_SHALLOW) || (state == MODE_DEEP);
  end

  p_no_deep_from_lpr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_LPRUN) |=> (state != MODE_DEEP));

  p_dbg_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dbgWake && !cfg.dbgEn && state != MODE_DEBUG) |=> (state != MODE_DEBUG));

  p_wake_norm_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_SHALLOW && irqWake && !dbgWake && cfg.wakeNorm) |=> (state == MODE_RUN));
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopReq,
  input  logic              irqWake,
  input  logic              dbgWake,
  input  logic              dbgResume,
  input  logic              memReq,
  input  logic              cfgWr,
  input  logic [CFG_W-1:0]  cfgData,
  output logic [MODE_W-1:0] mode,
  output logic [CFG_W-1:0]  cfgBits,
  output logic              regStandby,
  output logic              dbgClkOn,
  output logic              lprStat,
  output logic              memErr
);
  cfg_t  cfgQ;
  ctl_t  ctl;
  mode_e state;

  lpm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .irqWake(irqWake),
    .dbgWake(dbgWake), .dbgResume(dbgResume), .cfg(cfgQ),
    .state(state), .ctl(ctl)
  );

  lpm_regs uRegs (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .memReq(memReq), .ctl(ctl), .cfgQ(cfgQ),
    .regStandby(regStandby), .dbgClkOn(dbgClkOn), .memErr(memErr)
  );

  assign mode    = state;
  assign cfgBits = cfgQ;
  assign lprStat = (state == MODE_LPRUN);
endmodule

// File: tb/lpm_sequencer_test.sv
`timescale 1ns/1ps
module lpm_sequencer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 0, irqWake = 0, dbgWake = 0, dbgResume = 0, memReq = 0, cfgWr = 0;
  logic [5:0] cfgData = '0;
  logic [2:0] mode;
  logic [5:0] cfgBits;
  logic regStandby, dbgClkOn, lprStat, memErr;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  logic [2:0] mM;
  logic [5:0] mC;
  logic       mE;

  always #2 clk = ~clk;

  lpm_sequencer uut (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .irqWake(irqWake),
    .dbgWake(dbgWake), .dbgResume(dbgResume), .memReq(memReq),
    .cfgWr(cfgWr), .cfgData(cfgData), .mode(mode), .cfgBits(cfgBits),
    .regStandby(regStandby), .dbgClkOn(dbgClkOn), .lprStat(lprStat), .memErr(memErr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] modelCfg(input logic [5:0] cur, input logic wr,
                                          input logic [5:0] wd, input logic clr);
    logic [5:0] n;
    logic p, l;
    n = cur;
    if (wr) begin
      p = wd[3] & ~cur[4] & ~(wd[4] & ~cur[3]);
      l = wd[4] & ~cur[3] & ~(wd[3] & ~cur[4]);
      n = {wd[5], l, p, wd[2:0]};
    end
    if (clr) n[4] = 1'b0;
    return n;
  endfunction

  function automatic logic [3:0] modelMode(input logic [2:0] m, input logic [5:0] c,
                                           input logic st, input logic iw,
                                           input logic dw, input logic rs);
    logic [2:0] n;
    logic clr;
    logic dOk;
    n = m; clr = 0;
    dOk = dw & c[0];
    case (m)
      3'd0: if (dOk) n = 4; else if (st) n = (c[3] & ~c[0] & ~(c[1] & c[2])) ? 3 : 2;
            else if (c[4]) n = 1;
      3'd1: if (dOk) n = 4; else if (st) n = 2; else if (!c[4]) n = 0;
      3'd2: if (dOk) n = 4; else if (iw) begin
              if (c[5]) begin n = 0; clr = 1; end else n = c[4] ? 1 : 0;
            end
      3'd3: if (dOk) n = 4; else if (iw) n = 0;
      default: if (rs) n = 0;
    endcase
    return {clr, n};
  endfunction

  task automatic step(input logic st, input logic iw, input logic dw, input logic rs,
                      input logic mr, input logic wr, input logic [5:0] wd);
    logic [3:0] r;
    stopReq = st; irqWake = iw; dbgWake = dw; dbgResume = rs;
    memReq = mr; cfgWr = wr; cfgData = wd;
    @(posedge clk);
    r  = modelMode(mM, mC, st, iw, dw, rs);
    mE = mr & (mM == 2 || mM == 3);
    mC = modelCfg(mC, wr, wd, r[3]);
    mM = r[2:0];
    @(negedge clk);
    stopReq = 0; irqWake = 0; dbgWake = 0; dbgResume = 0;
    memReq = 0; cfgWr = 0; cfgData = '0;
  endtask

  task automatic idle(); step(0,0,0,0,0,0,6'h00); endtask
  task automatic wr(input logic [5:0] d); step(0,0,0,0,0,1,d); endtask

  task automatic doReset();
    rstN = 0;
    @(posedge clk);
    @(negedge clk);
    mM = 0; mC = 0; mE = 0;
    rstN = 1;
  endtask

  task automatic chkModel();
    logic inStop;
    inStop = (mM == 2 || mM == 3);
    chk("R7 mode", {5'd0, mode}, {5'd0, mM});
    chk("R5 cfg", {2'd0, cfgBits}, {2'd0, mC});
    chk("R9 standby", {7'd0, regStandby}, {7'd0, inStop & ~mC[0] & ~(mC[1] & mC[2])});
    chk("R9 clkon", {7'd0, dbgClkOn}, {7'd0, inStop & mC[0]});
    chk("R6 lprStat", {7'd0, lprStat}, {7'd0, mM == 3'd1});
    chk("R10 memErr", {7'd0, memErr}, {7'd0, mE});
  endtask

  initial begin
    #800000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    mM = 0; mC = 0; mE = 0;
    @(negedge clk);
    chk("R1 mode in reset", {5'd0, mode}, 8'd0);
    @(negedge clk);
    rstN = 1;
    chk("R1 mode", {5'd0, mode}, 8'd0);
    chk("R1 cfg", {2'd0, cfgBits}, 8'd0);
    chk("R1 outs", {4'd0, regStandby, dbgClkOn, lprStat, memErr}, 8'd0);

    // R2 shallow stop
    step(1,0,0,0,0,0,0);
    chk("R2 shallow", {5'd0, mode}, 8'd2);
    chk("R9 standby shallow", {7'd0, regStandby}, 8'd1);
    step(0,1,0,0,0,0,0);
    chk("R7 wake to run", {5'd0, mode}, 8'd0);

    // R3 deep and its demotion by debug enable
    wr(6'h08);
    chk("R5 ppd set", {2'd0, cfgBits}, 8'h08);
    step(1,0,0,0,0,0,0);
    chk("R3 deep", {5'd0, mode}, 8'd3);
    step(0,1,0,0,0,0,0);
    chk("R7 deep wake", {5'd0, mode}, 8'd0);
    wr(6'h09);
    step(1,0,0,0,0,0,0);
    chk("R3 dbg demote", {5'd0, mode}, 8'd2);
    chk("R9 clkon", {6'd0, dbgClkOn, regStandby}, 8'b10);
    step(0,0,0,0,1,0,0);
    chk("R10 err pulse", {7'd0, memErr}, 8'd1);
    idle();
    chk("R10 pulse ends", {7'd0, memErr}, 8'd0);
    step(0,0,1,0,0,0,0);
    chk("R8 enter debug", {5'd0, mode}, 8'd4);
    chk("R9 clk off in debug", {7'd0, dbgClkOn}, 8'd0);
    step(0,0,0,1,0,0,0);
    chk("R8 resume", {5'd0, mode}, 8'd0);

    // R4 voltage detect pair
    wr(6'h0E);
    step(1,0,0,0,0,0,0);
    chk("R4 both demote", {5'd0, mode}, 8'd2);
    chk("R4 no standby", {7'd0, regStandby}, 8'd0);
    step(0,1,0,0,0,0,0);
    wr(6'h0A);
    step(1,0,0,0,0,0,0);
    chk("R4 single deep", {5'd0, mode}, 8'd3);
    step(0,1,0,0,0,0,0);

    // R5 lockout
    wr(6'h08);
    wr(6'h18);
    chk("R5 lpr dropped", {2'd0, cfgBits}, 8'h08);
    wr(6'h00);
    wr(6'h18);
    chk("R5 both dropped", {2'd0, cfgBits}, 8'h00);
    wr(6'h10);
    chk("R6 mode lags", {5'd0, mode}, 8'd0);
    idle();
    chk("R6 lprun", {5'd0, mode}, 8'd1);
    chk("R6 lprStat", {7'd0, lprStat}, 8'd1);
    wr(6'h18);
    chk("R5 ppd dropped", {2'd0, cfgBits}, 8'h10);

    // R6 / R7 stop from low-power run and wake paths
    step(1,0,0,0,0,0,0);
    chk("R6 shallow from lpr", {5'd0, mode}, 8'd2);
    step(0,1,0,0,0,0,0);
    chk("R7 back to lprun", {5'd0, mode}, 8'd1);
    step(1,0,0,0,0,0,0);
    wr(6'h30);
    chk("R5 cfg in stop", {2'd0, cfgBits}, 8'h30);
    step(0,1,0,0,0,0,0);
    chk("R7 wake normal", {5'd0, mode}, 8'd0);
    chk("R7 lpr cleared", {2'd0, cfgBits}, 8'h20);
    idle();
    chk("R7 stays run", {6'd0, lprStat, mode == 3'd0}, 8'b01);
    wr(6'h00);

    // R8 ignored debug wake
    step(1,0,0,0,0,0,0);
    step(0,0,1,0,0,0,0);
    chk("R8 ignored", {5'd0, mode}, 8'd2);
    step(0,1,1,0,0,0,0);
    chk("R8 priority irq", {5'd0, mode}, 8'd0);
    step(0,0,0,0,1,0,0);
    chk("R10 no err in run", {7'd0, memErr}, 8'd0);

    // R11 reset out of stop
    wr(6'h11);
    idle();
    step(1,0,0,0,0,0,0);
    chk("R11 pre stop", {5'd0, mode}, 8'd2);
    doReset();
    chk("R11 mode", {5'd0, mode}, 8'd0);
    chk("R11 cfg", {2'd0, cfgBits}, 8'h00);

    // random phase against model
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 199) == 0) doReset();
      else step($urandom_range(0,7) == 0, $urandom_range(0,7) == 0,
                $urandom_range(0,15) == 0, $urandom_range(0,7) == 0,
                $urandom_range(0,3) == 0, $urandom_range(0,5) == 0,
                6'($urandom));
      chkModel();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule